// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns a software-chosen operating mode into six enable signals: the CPU clock, the main clock, the peripheral (sub-main) clock, the auxiliary clock, the DC generator of the digitally controlled oscillator, and the crystal oscillator. The CPU selects a mode by writing a three-bit code. The block holds that mode until the CPU writes a new one or an interrupt arrives.

When an interrupt is taken, the block saves the mode that is in force into a one-entry shadow and runs every clock, so the handler can execute. When the handler returns, the block restores the saved mode, and the device goes back to sleep at the level it had before. An interrupt that is taken inside a handler overwrites the shadow with the active mode. Every enable and the mode status come straight from flip-flops, so no enable changes between clock edges.

Top module: `lpm_clock_gate`

## Requirements
- R1: While reset is asserted and after it is released, the mode status is 0 (active) and all six enables are 1.
- R2: Mode code 0 (active) drives all six enables high.
- R3: Mode code 1 turns off the CPU and main clocks and keeps the peripheral clock, the auxiliary clock, the DC generator and the crystal running. The CPU and main clock enables are equal in every mode.
- R4: Mode code 2 has the same clock enables as code 1. The DC generator enable follows the input `dcgen_main_src`: it is 1 when that input is 1 and 0 when it is 0.
- R5: Mode code 3 turns off the CPU, main and peripheral clocks and keeps the auxiliary clock, the DC generator and the crystal on. The peripheral clock never runs without the auxiliary clock.
- R6: Mode code 4 matches code 3, except that the DC generator is off.
- R7: Mode code 5 turns off all six enables.
- R8: A cycle with `irq_enter` high saves the current mode into the shadow. At the next edge it sets the mode to active with all enables on.
- R9: A cycle with `irq_return` high, and `irq_enter` low, loads the mode from the shadow at the next edge.
- R10: Nested entry overwrites the shadow with the mode in force at that entry. An entry taken while active therefore makes the following returns restore active.
- R11: A write of code 6 or 7 is ignored, and the mode and enables keep their values.
- R12: When requests arrive in the same cycle, interrupt entry wins over return, and return wins over a mode write.
- R13: The mode status and enables change only at the clock edge that samples a request. They do not move before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode write strobe from the CPU |
| wr_code | input | 3 | Mode code to write (0 active, 1..5 sleep levels) |
| dcgen_main_src | input | 1 | 1 when the DC generator feeds the active-mode main clock |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Interrupt return strobe |
| en_cpu | output | 1 | CPU clock enable |
| en_main | output | 1 | Main clock enable |
| en_sub | output | 1 | Peripheral clock enable |
| en_aux | output | 1 | Auxiliary clock enable |
| en_dcgen | output | 1 | Oscillator DC generator enable |
| en_xtal | output | 1 | Crystal oscillator enable |
| mode_status | output | 3 | Mode currently in force |

## Verification
The bench walks through every sleep level and wakes from the deepest one. A design that saved the shadow too late would restore active instead of the deepest sleep level. It drives nested entries and returns. A design that kept the first saved value would return to a sleep level while the outer handler is still running. It fires all three requests in one cycle, where a wrong priority would either miss the wake-up or restore a stale mode. It also writes the illegal codes and changes the generator-source input while in mode 2. A decoder that mapped those codes to a sleep level, or ignored the source input, would show wrong enables one edge later.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int MODE_W = 3;
  localparam int NUM_EN = 6;
  localparam int NUM_MODES = 6;

  // bit positions inside the enable vector
  localparam int EN_CPU   = 5;
  localparam int EN_MAIN  = 4;
  localparam int EN_SUB   = 3;
  localparam int EN_AUX   = 2;
  localparam int EN_DCGEN = 1;
  localparam int EN_XTAL  = 0;

  typedef enum logic [MODE_W-1:0] {
    PM_RUN   = 3'd0,
    PM_IDLE  = 3'd1,
    PM_DOZE  = 3'd2,
    PM_NAP   = 3'd3,
    PM_SLEEP = 3'd4,
    PM_OFF   = 3'd5
  } pm_mode_e;

  typedef struct packed {
    logic cpu;
    logic main;
    logic sub;
    logic aux;
    logic dcgen;
    logic xtal;
  } clk_en_t;

  function automatic logic code_is_legal(input logic [MODE_W-1:0] code);
    return int'(code) < NUM_MODES;
  endfunction

  // Mode-to-enable decode. gen_keep holds the DC generator on in PM_DOZE.
  function automatic clk_en_t decode_enables(input pm_mode_e m, input logic gen_keep);
    clk_en_t e;
    e = '0;
    unique case (m)
      PM_RUN:   e = '{cpu:1'b1, main:1'b1, sub:1'b1, aux:1'b1, dcgen:1'b1, xtal:1'b1};
      PM_IDLE:  e = '{cpu:1'b0, main:1'b0, sub:1'b1, aux:1'b1, dcgen:1'b1, xtal:1'b1};
      PM_DOZE:  e = '{cpu:1'b0, main:1'b0, sub:1'b1, aux:1'b1, dcgen:gen_keep, xtal:1'b1};
      PM_NAP:   e = '{cpu:1'b0, main:1'b0, sub:1'b0, aux:1'b1, dcgen:1'b1, xtal:1'b1};
      PM_SLEEP: e = '{cpu:1'b0, main:1'b0, sub:1'b0, aux:1'b1, dcgen:1'b0, xtal:1'b1};
      PM_OFF:   e = '0;
      default:  e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_code,
  output pm_mode_e          mode_nxt,
  output pm_mode_e          mode_q,
  output pm_mode_e          shadow_q,
  output logic              ev_enter,
  output logic              ev_return,
  output logic              ev_write_ok,
  output logic              ev_write_bad
);

  // arbitration: entry > return > write
  assign ev_enter     = irq_enter;
  assign ev_return    = irq_return & ~irq_enter;
  assign ev_write_ok  = wr_en & ~irq_enter & ~irq_return & code_is_legal(wr_code);
  assign ev_write_bad = wr_en & ~irq_enter & ~irq_return & ~code_is_legal(wr_code);

  always_comb begin
    mode_nxt = mode_q;
    if (ev_enter)         mode_nxt = PM_RUN;
    else if (ev_return)   mode_nxt = shadow_q;
    else if (ev_write_ok) mode_nxt = pm_mode_e'(wr_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_RUN;
      shadow_q <= PM_RUN;
    end else begin
      mode_q <= mode_nxt;
      if (ev_enter) shadow_q <= mode_q;
    end
  end

endmodule

// File: rtl/lpm_enable_reg.sv
module lpm_enable_reg
  import lpm_pkg::*;
#(
  parameter int WIDTH = NUM_EN
)(
  input  logic             clk,
  input  logic             rst_n,
  input  pm_mode_e         mode_nxt,
  input  logic             gen_keep,
  output logic [WIDTH-1:0] en_q
);

  clk_en_t          dec;
  logic [WIDTH-1:0] dec_vec;

  assign dec     = decode_enables(mode_nxt, gen_keep);
  assign dec_vec = WIDTH'(dec);

  // one flop per enable, each resetting to running
  for (genvar i = 0; i < WIDTH; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[i] <= 1'b1;
      else        en_q[i] <= dec_vec[i];
    end
  end

endmodule

// File: rtl/lpm_clock_gate.sv
module lpm_clock_gate
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_code,
  input  logic       dcgen_main_src,
  input  logic       irq_enter,
  input  logic       irq_return,
  output logic       en_cpu,
  output logic       en_main,
  output logic       en_sub,
  output logic       en_aux,
  output logic       en_dcgen,
  output logic       en_xtal,
  output logic [2:0] mode_status
);

  pm_mode_e          mode_nxt;
  pm_mode_e          mode_q;
  pm_mode_e          shadow_q;
  logic              ev_enter;
  logic              ev_return;
  logic              ev_write_ok;
  logic              ev_write_bad;
  logic [NUM_EN-1:0] en_vec;

  lpm_mode_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_enter    (irq_enter),
    .irq_return   (irq_return),
    .wr_en        (wr_en),
    .wr_code      (wr_code),
    .mode_nxt     (mode_nxt),
    .mode_q       (mode_q),
    .shadow_q     (shadow_q),
    .ev_enter     (ev_enter),
    .ev_return    (ev_return),
    .ev_write_ok  (ev_write_ok),
    .ev_write_bad (ev_write_bad)
  );

  lpm_enable_reg #(.WIDTH(NUM_EN)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_nxt (mode_nxt),
    .gen_keep (dcgen_main_src),
    .en_q     (en_vec)
  );

  assign en_cpu      = en_vec[EN_CPU];
  assign en_main     = en_vec[EN_MAIN];
  assign en_sub      = en_vec[EN_SUB];
  assign en_aux      = en_vec[EN_AUX];
  assign en_dcgen    = en_vec[EN_DCGEN];
  assign en_xtal     = en_vec[EN_XTAL];
  assign mode_status = mode_q;

endmodule

// File: rtl/lpm_clock_gate_chk.sv
module lpm_clock_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_enter,
  input logic       irq_return,
  input logic [2:0] mode_q,
  input logic [2:0] shadow_q,
  input logic [5:0] en_vec,
  input logic       ev_enter,
  input logic       ev_return,
  input logic       ev_write_ok,
  input logic       ev_write_bad
);

  assert_enter_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> (mode_q == 3'd0 && en_vec == 6'h3F));

  assert_enter_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> shadow_q == $past(mode_q));

  assert_return_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter) |=> mode_q == $past(shadow_q));

  assert_bad_code_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_bad |=> $stable(mode_q));

  assert_off_all_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd5) |-> en_vec == 6'h00);

  assert_cpu_main_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_vec[5] == en_vec[4]);

  assert_sub_needs_aux_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_vec[3] |-> en_vec[2]);

  assert_one_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_enter, ev_return, ev_write_ok, ev_write_bad}));

endmodule

bind lpm_clock_gate lpm_clock_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_enter    (irq_enter),
  .irq_return   (irq_return),
  .mode_q       (mode_q),
  .shadow_q     (shadow_q),
  .en_vec       (en_vec),
  .ev_enter     (ev_enter),
  .ev_return    (ev_return),
  .ev_write_ok  (ev_write_ok),
  .ev_write_bad (ev_write_bad)
);

// File: tb/sim_lpm_clock_gate.sv
`timescale 1ns/1ps
module sim_lpm_clock_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_code = 3'd0;
  logic       dcgen_main_src = 1'b0;
  logic       irq_enter = 1'b0;
  logic       irq_return = 1'b0;
  logic       en_cpu, en_main, en_sub, en_aux, en_dcgen, en_xtal;
  logic [2:0] mode_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] mode;
    logic [5:0] en;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // bench-side reference state
  logic [2:0] m_mode = 3'd0;
  logic [2:0] m_shadow = 3'd0;

  always #2.5 clk = ~clk;

  lpm_clock_gate u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .dcgen_main_src(dcgen_main_src), .irq_enter(irq_enter), .irq_return(irq_return),
    .en_cpu(en_cpu), .en_main(en_main), .en_sub(en_sub), .en_aux(en_aux),
    .en_dcgen(en_dcgen), .en_xtal(en_xtal), .mode_status(mode_status)
  );

  function automatic logic [5:0] ref_en(input logic [2:0] m, input logic src);
    logic c, mn, s, a, g, x;
    c  = (m == 3'd0);
    mn = (m == 3'd0);
    s  = (m <= 3'd2);
    a  = (m <= 3'd4);
    x  = (m <= 3'd4);
    g  = (m == 3'd0) || (m == 3'd1) || (m == 3'd3) || ((m == 3'd2) && src);
    return {c, mn, s, a, g, x};
  endfunction

  function automatic logic [5:0] dut_en();
    return {en_cpu, en_main, en_sub, en_aux, en_dcgen, en_xtal};
  endfunction

  task automatic compare(input string tag, input logic [2:0] em, input logic [5:0] ee);
    checks++;
    if (mode_status !== em || dut_en() !== ee) begin
      errors++;
      $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
               tag, mode_status, dut_en(), em, ee);
    end
  endtask

  // driver: one request set per cycle, expected result pushed to the queue
  task automatic op(input string tag, input logic ent, input logic ret,
                    input logic wr, input logic [2:0] code, input logic src,
                    input bit hold_chk);
    logic [2:0] old_mode;
    logic [5:0] old_en;
    exp_t item;
    old_mode = m_mode;
    old_en   = exp_q.size() == 0 ? dut_en() : exp_q[$].en;
    @(negedge clk);
    irq_enter = ent; irq_return = ret; wr_en = wr; wr_code = code; dcgen_main_src = src;
    if (ent) begin
      m_shadow = m_mode;
      m_mode   = 3'd0;
    end else if (ret) begin
      m_mode = m_shadow;
    end else if (wr && code <= 3'd5) begin
      m_mode = code;
    end
    item.mode = m_mode;
    item.en   = ref_en(m_mode, src);
    item.tag  = tag;
    exp_q.push_back(item);
    if (hold_chk) begin
      #1;
      compare("R13 (before edge)", old_mode, old_en);
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        compare(it.tag, it.mode, it.en);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #7;
    compare("R1 in reset", 3'd0, 6'h3F);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", 3'd0, 6'h3F);

    op("R2 active idle", 0, 0, 0, 3'd0, 0, 0);
    op("R3 mode 1",      0, 0, 1, 3'd1, 0, 1);
    op("R4 mode 2 src0", 0, 0, 1, 3'd2, 0, 1);
    op("R4 mode 2 src1", 0, 0, 0, 3'd0, 1, 0);
    op("R4 mode 2 src0 again", 0, 0, 0, 3'd0, 0, 0);
    op("R5 mode 3",      0, 0, 1, 3'd3, 0, 1);
    op("R6 mode 4",      0, 0, 1, 3'd4, 1, 0);
    op("R7 mode 5",      0, 0, 1, 3'd5, 1, 1);
    op("R8 wake from 5", 1, 0, 0, 3'd0, 0, 1);
    op("R2 active in handler", 0, 0, 0, 3'd0, 0, 0);
    op("R9 return to 5", 0, 1, 0, 3'd0, 0, 1);

    op("R6 mode 4 set",  0, 0, 1, 3'd4, 0, 0);
    op("R8 enter outer", 1, 0, 0, 3'd0, 0, 0);
    op("R10 enter nested", 1, 0, 0, 3'd0, 0, 0);
    op("R10 return inner", 0, 1, 0, 3'd0, 0, 0);
    op("R10 return outer", 0, 1, 0, 3'd0, 0, 0);

    op("R5 mode 3 set",  0, 0, 1, 3'd3, 0, 0);
    op("R11 code 6",     0, 0, 1, 3'd6, 0, 0);
    op("R11 code 7",     0, 0, 1, 3'd7, 0, 0);

    op("R12 all three",  1, 1, 1, 3'd5, 0, 0);
    op("R12 ret over wr", 0, 1, 1, 3'd1, 0, 0);
    op("R4 mode 2 via write src1", 0, 0, 1, 3'd2, 1, 0);
    op("R12 enter over wr", 1, 0, 1, 3'd5, 1, 0);
    op("R9 back to 2",   0, 1, 0, 3'd0, 1, 0);
    op("R2 write active", 0, 0, 1, 3'd0, 0, 1);
    op("R2 idle tail",   0, 0, 0, 3'd0, 0, 0);

    @(negedge clk);
    irq_enter = 0; irq_return = 0; wr_en = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule